// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter with Queue

This block is the send half of an asynchronous serial port. Software pushes bytes one at a time into a 16-deep queue. A frame shifter takes them out in order and sends each one on the serial output line. A baud tick that is generated outside the block paces the shifter, one tick per bit. Each frame carries a low start bit, eight data bits with the least significant bit first, an even parity bit and a high stop bit.

When flow control is enabled, the peer's clear-to-send input decides whether a new character may begin. The check is made only at a character boundary, so a frame that is already on the line always finishes. The block reports whether the queue is empty and whether a frame is being shifted. It also gives a one-cycle event at the moment the last queued character leaves the queue and its start bit appears. A write to a full queue is dropped and sets a sticky overflow flag. A queue clear discards the waiting bytes and resets that flag.

Top module: `flowgated_uart_tx`

## Requirements
- R1: After synchronous active-low reset, txd is 1, q_empty is 1, and tx_busy, last_taken and q_overflow are 0.
- R2: A frame is a 0 start bit, then wr bits 0 through 7 in that order, then a parity bit equal to the XOR of the eight data bits (even parity), then a 1 stop bit. Each bit changes only on a clock edge where baud_tick is 1 and lasts one tick interval. txd is 1 whenever no frame is active.
- R3: The queue holds up to 16 bytes. Bytes are sent in the order in which they were accepted.
- R4: With flow_en=1, a character starts only on a tick edge where cts is 1. That edge must also find a byte queued and the shifter either idle or at the end of a stop bit. This lets frames run back to back with no gap.
- R5: With flow_en=0, cts has no effect, and queued bytes are sent as though cts were 1.
- R6: Dropping cts in the middle of a frame does not abort that frame. Only the next character is held back.
- R7: q_empty is 1 exactly when no byte is waiting in the queue. A byte that is being shifted does not count as waiting.
- R8: tx_busy is 1 from the cycle the start bit appears until the tick that ends the stop bit.
- R9: last_taken is a one-cycle pulse. It appears in the first cycle of a start bit when that character emptied the queue and no write was accepted on the same edge. It is 0 at all other times.
- R10: A write while 16 bytes are held is dropped and sets q_overflow, which stays at 1 until a clear.
- R11: tx_clear discards every waiting byte and clears q_overflow. A write in the same cycle is ignored, and no character starts in that cycle. A frame that is already being shifted completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| tx_clear | input | 1 | Discard queued bytes and clear overflow |
| cts | input | 1 | Peer clear-to-send, 1 = may send |
| flow_en | input | 1 | 1 = gate character starts on cts |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial output, idles high |
| q_empty | output | 1 | No byte waiting in the queue |
| tx_busy | output | 1 | A frame is being shifted |
| last_taken | output | 1 | Pulse when the final queued byte starts |
| q_overflow | output | 1 | Sticky: a write to a full queue was dropped |

## Verification
The frame path is first tried with a single byte on an open line. Next, bytes are queued while cts is held low and then released, which shows the difference between gating at a boundary and merely delaying. The bench then overfills the queue to confirm that exactly the seventeenth byte is lost, and it clears the queue both while idle and in the middle of a frame. Random rounds mix burst lengths, byte values, flow_en settings and cts toggling on every cycle. An independent line monitor decodes every frame, so these rounds distinguish an aborted frame, a start that ignored cts, reordered data and a last-byte event raised on the wrong character.

// File: rtl/flowtx_pkg.sv
// Package: shared widths and frame construction for the flow-controlled
// transmitter. Assumes 8 data bits, even parity and one stop bit.
package flowtx_pkg;
    localparam int CHAR_W  = 8;
    localparam int FRAME_W = CHAR_W + 3;

    // Frame image, shifted out from bit 0: start, data LSB first, parity, stop
    function automatic logic [FRAME_W-1:0] build_frame(input logic [CHAR_W-1:0] d);
        return {1'b1, ^d, d, 1'b0};
    endfunction
endpackage

// File: rtl/flowtx_fifo.sv
// Module: flowtx_fifo
// Byte queue with occupancy count and a sticky overflow flag.
// Assumes: rd_en is raised only when the queue is not empty, and a clear
// takes priority over a write in the same cycle.
module flowtx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    input  logic             clear,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             push_ok,
    output logic             ovf
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = wr_en && !clear && !full;
    assign head    = mem[rd_ptr];

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write for accepted bytes
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_data;
    end

    // Pointers, count and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (rd_en)   rd_ptr <= nxt(rd_ptr);
            if (push_ok && !rd_en)      count <= count + 1'b1;
            else if (rd_en && !push_ok) count <= count - 1'b1;
            if (wr_en && full)          ovf   <= 1'b1;
        end
    end

    // R3
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R10
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(wr_en && full && !clear));
    // R11
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !ovf));
endmodule

// File: rtl/flowtx_ctrl.sv
// Module: flowtx_ctrl
// Start permission from the flow-control inputs, plus the registered
// last-character event. Assumes pop is a single-cycle strobe.
module flowtx_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flow_en,
    input  logic cts,
    input  logic clear,
    input  logic pop,
    input  logic one_left,
    input  logic push_ok,
    output logic start_ok,
    output logic last_taken
);
    // Permission: cts matters only with flow control on; no start during clear
    always_comb begin
        start_ok = (cts || !flow_en) && !clear;
    end

    // Event register: pop that leaves the queue empty with no refill
    always_ff @(posedge clk) begin
        if (!rst_n) last_taken <= 1'b0;
        else        last_taken <= pop && one_left && !push_ok;
    end
endmodule

// File: rtl/flowtx_shifter.sv
// Module: flowtx_shifter
// Frame shift register paced by baud_tick. Loads a new frame when idle or at
// the end of a stop bit, if a byte is available and starting is permitted.
// Assumes baud_tick is a single-cycle pulse.
module flowtx_shifter
    import flowtx_pkg::*;
#(
    localparam int IDX_W = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_ok,
    input  logic              avail,
    input  logic [CHAR_W-1:0] data,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh;
    logic [IDX_W-1:0]   idx;
    logic               at_boundary;

    assign at_boundary = !busy || (idx == LAST);
    assign pop         = tick && start_ok && avail && at_boundary;
    assign txd         = sh[0];

    // Frame sequencing: load, shift one bit per tick, drop to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            idx  <= '0;
            busy <= 1'b0;
        end else if (tick) begin
            if (pop) begin
                sh   <= build_frame(data);
                idx  <= '0;
                busy <= 1'b1;
            end else if (busy && idx == LAST) begin
                sh   <= '1;
                busy <= 1'b0;
            end else if (busy) begin
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                idx  <= idx + 1'b1;
            end
        end
    end

    // R2
    txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));
    // R6
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx != LAST) |=> busy);
endmodule

// File: rtl/flowgated_uart_tx.sv
// Module: flowgated_uart_tx
// Queued serial transmitter with clear-to-send gating at character
// boundaries. Assumes an external baud tick, one pulse per bit time.
module flowgated_uart_tx
    import flowtx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              tx_clear,
    input  logic              cts,
    input  logic              flow_en,
    input  logic              baud_tick,
    output logic              txd,
    output logic              q_empty,
    output logic              tx_busy,
    output logic              last_taken,
    output logic              q_overflow
);
    logic [CHAR_W-1:0] head;
    logic [CNT_W-1:0]  count;
    logic              pop, push_ok, start_ok;

    flowtx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .clear(tx_clear), .head(head), .count(count),
        .empty(q_empty), .push_ok(push_ok), .ovf(q_overflow)
    );

    flowtx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .cts(cts),
        .clear(tx_clear), .pop(pop), .one_left(count == CNT_W'(1)),
        .push_ok(push_ok), .start_ok(start_ok), .last_taken(last_taken)
    );

    flowtx_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start_ok(start_ok),
        .avail(!q_empty), .data(head), .pop(pop), .txd(txd), .busy(tx_busy)
    );

    // R9
    last_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_taken |-> (q_empty && tx_busy && !txd));
    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(cts || !flow_en));
endmodule

// File: tb/flowgated_uart_tx_tb.sv
module flowgated_uart_tx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, tx_clear = 1'b0, cts = 1'b1, flow_en = 1'b1, baud_tick = 1'b0;
    logic [7:0] wr_data = '0;
    logic txd, q_empty, tx_busy, last_taken, q_overflow;

    always #5 clk = ~clk;

    flowgated_uart_tx u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_clear(tx_clear), .cts(cts), .flow_en(flow_en), .baud_tick(baud_tick),
        .txd(txd), .q_empty(q_empty), .tx_busy(tx_busy),
        .last_taken(last_taken), .q_overflow(q_overflow)
    );

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

    // Baud tick every 4 clocks, driven away from the edge
    int tdiv = 0;
    always @(posedge clk) begin
        #2;
        tdiv = (tdiv + 1) % 4;
        baud_tick = (tdiv == 0);
    end

    // Random cts toggler for stress rounds
    bit rand_cts = 0;
    always @(posedge clk) begin
        #2;
        if (rand_cts) cts = ($urandom % 3) != 0;
    end

    // Inputs as seen at each edge
    logic tick_e = 0, cts_e = 0, flow_e = 0;
    always @(posedge clk) begin
        tick_e <= baud_tick;
        cts_e  <= cts;
        flow_e <= flow_en;
    end

    // Line monitor and bench model
    logic [7:0] exp_q[$];
    int wr_acc = 0, starts = 0, midx = 0;
    bit mbusy = 0;
    logic [7:0] mdata;
    logic mpar;
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_last;
            exp_last = 0;
            if (tick_e) begin
                if (mbusy && midx < 10) begin
                    midx++;
                    if (midx <= 8) mdata[midx-1] = txd;
                    else if (midx == 9) mpar = txd;
                    else begin
                        chk(txd == 1'b1, "R2", "stop bit", txd, 1);
                        if (exp_q.size() > 0) begin
                            chk(mdata == exp_q[0], "R3", "frame data", mdata, exp_q[0]);
                            chk(mpar == even_par(exp_q[0]), "R2", "parity", mpar, even_par(exp_q[0]));
                            void'(exp_q.pop_front());
                        end else chk(0, "R3", "unexpected frame", mdata, -1);
                    end
                end else begin
                    mbusy = (txd == 1'b0);
                    if (mbusy) begin
                        midx = 0;
                        starts++;
                        chk(cts_e || !flow_e, "R4", "start while cts low", cts_e, 1);
                        chk(exp_q.size() > 0, "R11", "start with nothing queued", exp_q.size(), 1);
                        exp_last = (wr_acc == starts);
                    end
                end
            end
            chk(last_taken == exp_last, "R9", "last_taken", last_taken, exp_last);
            chk(tx_busy == mbusy, "R8", "tx_busy", tx_busy, mbusy);
            chk(q_empty == (wr_acc == starts), "R7", "q_empty", q_empty, wr_acc == starts);
        end
    end

    task automatic write_byte(input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = d;
        #5;
        if ((wr_acc - starts) < 16) begin
            exp_q.push_back(d);
            wr_acc++;
        end
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic do_clear();
        @(posedge clk); #2;
        tx_clear = 1'b1;
        #5;
        wr_acc = starts;
        if (mbusy) begin
            while (exp_q.size() > 1) void'(exp_q.pop_back());
        end else exp_q.delete();
        @(posedge clk); #2;
        tx_clear = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        @(posedge clk); #2;
        rand_cts = 0; cts = 1'b1;
        while ((wr_acc != starts || mbusy) && n < 3000) begin
            @(posedge clk); n++;
        end
        repeat (8) @(posedge clk);
        chk(exp_q.size() == 0, "R3", "all bytes sent", exp_q.size(), 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int s0;
        void'($urandom(32'd20240611));
        idle(4);
        @(negedge clk);
        // R1 reset state
        chk(txd == 1, "R1", "txd", txd, 1);
        chk(q_empty == 1, "R1", "q_empty", q_empty, 1);
        chk(tx_busy == 0, "R1", "tx_busy", tx_busy, 0);
        chk(last_taken == 0, "R1", "last_taken", last_taken, 0);
        chk(q_overflow == 0, "R1", "q_overflow", q_overflow, 0);
        @(posedge clk); #2; rst_n = 1'b1;

        // R2 single frame on an open line
        write_byte(8'hA5);
        drain();
        chk(starts == 1, "R2", "frame count", starts, 1);

        // R4 blocked by cts, then released
        cts = 1'b0;
        write_byte(8'h3C); write_byte(8'h01); write_byte(8'hFF);
        s0 = starts;
        idle(200);
        chk(starts == s0, "R4", "held while cts low", starts, s0);
        drain();
        chk(starts == s0 + 3, "R4", "released frames", starts, s0 + 3);

        // R10 overflow on the 17th byte
        @(posedge clk); #2; cts = 1'b0;
        s0 = starts;
        for (int i = 0; i < 17; i++) write_byte(8'(i * 13 + 7));
        @(negedge clk);
        chk(q_overflow == 1, "R10", "overflow set", q_overflow, 1);
        chk(wr_acc - s0 == 16, "R10", "accepted", wr_acc - s0, 16);
        drain();
        chk(starts == s0 + 16, "R10", "frames after overflow", starts, s0 + 16);
        @(negedge clk);
        chk(q_overflow == 1, "R10", "overflow sticky", q_overflow, 1);

        // R11 clear while idle
        @(posedge clk); #2; cts = 1'b0;
        for (int i = 0; i < 5; i++) write_byte(8'h50 + 8'(i));
        do_clear();
        @(negedge clk);
        chk(q_empty == 1, "R11", "empty after clear", q_empty, 1);
        chk(q_overflow == 0, "R11", "overflow cleared", q_overflow, 0);
        s0 = starts;
        @(posedge clk); #2; cts = 1'b1;
        idle(200);
        chk(starts == s0, "R11", "nothing sent after clear", starts, s0);

        // R11 clear during a frame: the frame completes, the rest is gone
        s0 = starts;
        for (int i = 0; i < 4; i++) write_byte(8'hC0 + 8'(i));
        while (!mbusy) @(posedge clk);
        do_clear();
        drain();
        chk(starts == s0 + 1, "R11", "only in-flight frame sent", starts, s0 + 1);

        // R5 flow control off: cts ignored
        @(posedge clk); #2; flow_en = 1'b0; cts = 1'b0;
        s0 = starts;
        write_byte(8'h81); write_byte(8'h7E); write_byte(8'h00);
        idle(200);
        chk(starts == s0 + 3, "R5", "sent with cts low", starts, s0 + 3);
        drain();
        @(posedge clk); #2; flow_en = 1'b1;

        // R6 cts drop in mid-frame
        s0 = starts;
        write_byte(8'h96); write_byte(8'h69);
        while (!(mbusy && midx >= 3)) @(posedge clk);
        #2; cts = 1'b0;
        idle(100);
        chk(starts == s0 + 1, "R6", "second held", starts, s0 + 1);
        chk(exp_q.size() == 1, "R6", "first frame completed", exp_q.size(), 1);
        drain();

        // Random rounds (R3 ordering, R4/R5 gating, R9 event)
        for (int r = 0; r < 25; r++) begin
            int n;
            n = 1 + ($urandom % 16);
            @(posedge clk); #2;
            flow_en = ($urandom % 4) != 0;
            rand_cts = 1;
            for (int i = 0; i < n; i++) begin
                write_byte(8'($urandom));
                idle($urandom % 12);
            end
            idle($urandom % 60);
            drain();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule